// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Retransmit

A single-clock first-in first-out buffer of configurable width and power-of-two depth. A master reset selects one of two output disciplines, and the selection holds until the next master reset. In standard mode a word reaches `rd_data` one clock after a read request is accepted. In fall-through mode the oldest stored word is moved to the output register without a request, and the read enable only acknowledges that it has been taken.

Two flags report status, and each keeps the same polarity in both modes. `ef_or` is high when there is something to read. In standard mode it tracks whether memory holds any word; in fall-through mode it tracks whether the output register holds a valid word. `ff_ir` is high while the memory can accept a write. A half-full flag and an occupancy count are provided for flag logic outside the block. A partial reset empties the buffer and keeps the selected mode. A retransmit moves only the read side back to physical location zero, so data written since the last reset can be read again.

Top module: `rtx_fifo`

## Requirements
- R1: While `mrst` is high at a rising edge, both pointers are cleared, `rd_data` becomes 0, `count` becomes 0 and `fwft_sel` is captured as the mode (1 = fall-through, 0 = standard).
- R2: While `prst` is high at a rising edge (and `mrst` low), the pointers are cleared, `rd_data` becomes 0 and `count` becomes 0, and the mode captured at the last master reset is kept whatever `fwft_sel` is.
- R3: In standard mode `ef_or` is 0 exactly when memory holds no word. A read (`rd_en` high with `ef_or` high) places the oldest word on `rd_data` after that edge. Otherwise `rd_data` holds its value.
- R4: In fall-through mode a word written into an empty buffer is on `rd_data`, with `ef_or` high, one edge after the write edge and without any read request. `rd_en` high while `ef_or` is high consumes that word, and the next stored word is presented after the same edge.
- R5: `ff_ir` is 0 exactly when memory holds DEPTH words. `count` is the number of words in memory, plus 1 in fall-through mode while the output register holds a valid word.
- R6: A write while `ff_ir` is 0 is ignored. A read while `ef_or` is 0 is ignored and changes neither `rd_data` nor `count`.
- R7: `half_full` is 1 exactly when `count` is greater than DEPTH/2.
- R8: `rt` high at an edge sets the read pointer to location 0, and ignores a read requested in that cycle. A write in the same cycle still completes. `ef_or` is 0 while `rt` is high, and later reads return the words again starting from the first one written since reset. This requires that no more than DEPTH words have been written since reset.
- R9: Words leave in the order they were written, and a simultaneous accepted read and write leave `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| mrst | input | 1 | Synchronous master reset, active high |
| prst | input | 1 | Synchronous partial reset, active high |
| fwft_sel | input | 1 | Mode select, captured during master reset |
| rt | input | 1 | Retransmit, rewinds the read pointer |
| wr_en | input | 1 | Write enable |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read enable (acknowledge in fall-through mode) |
| rd_data | output | DW | Output register |
| ef_or | output | 1 | Data available: not-empty (standard) or output-ready (fall-through) |
| ff_ir | output | 1 | Space available: not-full (standard) or input-ready (fall-through) |
| half_full | output | 1 | Occupancy above half of the depth |
| count | output | AW+1 | Occupancy in words |

## Verification
Both modes go through the same sequence. A plain fill, a partial drain, a retransmit, and a drain past empty show whether the rewind goes back to the first written word and whether reads on an empty buffer are ignored. Fills beyond capacity, with and without a read in the same cycle, check that writes are refused at full and that the fall-through output register adds one word of capacity. Two interleaved read and write patterns check ordering and the count under simultaneous traffic. A partial reset with the mode select inverted, followed by a single write, shows that the mode was kept, because only fall-through mode presents that word without a read.

// File: rtl/rtx_fifo.sv
`timescale 1ns/1ps
module rtx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_sel,
  input  logic          rt,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          ef_or,
  output logic          ff_ir,
  output logic          half_full,
  output logic [AW:0]   count
);
  localparam logic [AW:0] CAP  = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF = (AW+1)'(DEPTH / 2);

  logic          fwft_q;
  logic          ov;
  logic [AW:0]   wptr, rptr, mcnt;
  logic [DW-1:0] mem [DEPTH];
  logic          full, has, do_wr, pop;

  assign mcnt  = wptr - rptr;
  assign full  = (mcnt == CAP);
  assign has   = (mcnt != '0);
  assign do_wr = wr_en & ~full;
  assign pop   = ~rt & has & (fwft_q ? (~ov | rd_en) : rd_en);

  always_ff @(posedge clk)
    if (!mrst && !prst && do_wr) mem[wptr[AW-1:0]] <= wr_data;

  always_ff @(posedge clk) begin
    if (mrst || prst) begin
      if (mrst) fwft_q <= fwft_sel;
      wptr    <= '0;
      rptr    <= '0;
      ov      <= 1'b0;
      rd_data <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (rt) begin
        rptr <= '0;
        ov   <= 1'b0;
      end else if (pop) begin
        rptr    <= rptr + 1'b1;
        rd_data <= mem[rptr[AW-1:0]];
        ov      <= fwft_q;
      end else if (rd_en && ov) begin
        ov <= 1'b0;
      end
    end
  end

  assign count     = mcnt + (AW+1)'(ov);
  assign ef_or     = ~rt & (fwft_q ? ov : has);
  assign ff_ir     = ~full;
  assign half_full = (count > HALF);
endmodule

// File: rtl/rtx_fifo_chk.sv
`timescale 1ns/1ps
module rtx_fifo_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          mrst,
  input logic          prst,
  input logic          rt,
  input logic          rd_en,
  input logic          fwft_q,
  input logic [DW-1:0] rd_data,
  input logic          ef_or,
  input logic          ff_ir,
  input logic          half_full,
  input logic [AW:0]   count
);
  a_r1_master_clear: assert property (@(posedge clk)
    mrst |=> (count == '0 && rd_data == '0 && !ef_or));

  a_r2_mode_kept: assert property (@(posedge clk) disable iff (mrst)
    prst |=> (fwft_q == $past(fwft_q)));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (mrst)
    (!prst && !rt && !ff_ir && !rd_en) |=> (count == $past(count)));

  a_r6_no_underflow: assert property (@(posedge clk) disable iff (mrst)
    (!prst && !rt && !fwft_q && !ef_or && rd_en) |=> $stable(rd_data));

  a_r7_half_flag: assert property (@(posedge clk) disable iff (mrst)
    half_full |-> (count > (AW+1)'(DEPTH / 2)));

  a_r8_rt_not_ready: assert property (@(posedge clk) disable iff (mrst)
    rt |-> !ef_or);

  a_r5_full_count: assert property (@(posedge clk) disable iff (mrst)
    !ff_ir |-> (count >= (AW+1)'(DEPTH)));
endmodule

bind rtx_fifo rtx_fifo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .mrst(mrst), .prst(prst), .rt(rt), .rd_en(rd_en),
  .fwft_q(fwft_q), .rd_data(rd_data), .ef_or(ef_or), .ff_ir(ff_ir),
  .half_full(half_full), .count(count)
);

// File: tb/rtx_fifo_bench.sv
`timescale 1ns/1ps
module rtx_fifo_bench;
  localparam int DW = 8;
  localparam int DEPTH = 8;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic mrst = 1'b1, prst = 1'b0, fwft_sel = 1'b0, rt = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic ef_or, ff_ir, half_full;
  logic [AW:0] count;

  always #4 clk = ~clk;

  rtx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rtx_fifo (
    .clk(clk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel), .rt(rt),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .ef_or(ef_or), .ff_ir(ff_ir), .half_full(half_full), .count(count)
  );

  int nchk = 0, nerr = 0;
  int wi = 0, ri = 0, ov = 0, eq = 0, mfw = 0;

  function automatic int dat(int k);
    return (k * 37 + 5) & 8'hFF;
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    int mc = wi - ri;
    int cnt = mc + (mfw ? ov : 0);
    chk(mfw ? "R4 ef_or" : "R3 ef_or", int'(ef_or), mfw ? ov : int'(mc != 0));
    chk("R5 ff_ir", int'(ff_ir), int'(mc != DEPTH));
    chk("R5 count", int'(count), cnt);
    chk("R7 half_full", int'(half_full), int'(cnt > DEPTH / 2));
    chk("R9 rd_data", int'(rd_data), eq);
  endtask

  task automatic tick(bit w, bit r, bit t);
    int mc = wi - ri;
    wr_en = w; rd_en = r; rt = t; wr_data = DW'(dat(wi));
    #1;
    if (t) chk("R8 ef_or low during retransmit", int'(ef_or), 0);
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0; rt = 1'b0;
    if (t) begin
      ri = 0; ov = 0;
    end else if (mc > 0 && (mfw ? (ov == 0 || r) : r)) begin
      eq = dat(ri); ri++; ov = mfw;
    end else if (r && ov != 0) begin
      ov = 0;
    end
    if (w && mc != DEPTH) wi++;
    #1;
    check_all();
  endtask

  task automatic do_reset(bit master, bit sel);
    mrst = master; prst = !master; fwft_sel = sel;
    @(posedge clk);
    #1;
    mrst = 1'b0; prst = 1'b0; fwft_sel = !sel;
    if (master) mfw = sel;
    wi = 0; ri = 0; ov = 0; eq = 0;
    #1;
    chk(master ? "R1 count" : "R2 count", int'(count), 0);
    chk(master ? "R1 rd_data" : "R2 rd_data", int'(rd_data), 0);
    chk(master ? "R1 ef_or" : "R2 ef_or", int'(ef_or), 0);
    check_all();
  endtask

  task automatic run_mode(bit fw);
    do_reset(1'b1, fw);
    for (int i = 0; i < DEPTH; i++) tick(1, 0, 0);
    for (int i = 0; i < 5; i++) tick(0, 1, 0);
    tick(0, 1, 1);
    chk("R8 count after rewind", int'(count), DEPTH);
    tick(0, 0, 0);
    chk("R8 first word again", int'(rd_data), fw ? dat(0) : dat(4));
    for (int i = 0; i < DEPTH + 3; i++) tick(0, 1, 0);
    chk("R6 empty reads ignored", int'(count), 0);
    for (int i = 0; i < DEPTH + 3; i++) tick(1, 0, 0);
    chk("R6 writes at full ignored", int'(count), DEPTH + (fw ? 1 : 0));
    tick(1, 1, 0);
    tick(1, 1, 0);
    for (int i = 0; i < 90; i++) tick(i % 3 != 0, i % 2 == 0, 0);
    for (int i = 0; i < 90; i++) tick(i % 5 < 3, i % 7 < 3, 0);
    for (int i = 0; i < 40; i++) tick(i % 4 != 3, i % 4 != 0, 0);
    for (int i = 0; i < 3; i++) tick(1, 0, 0);
    do_reset(1'b0, !fw);
    tick(1, 0, 0);
    tick(0, 0, 0);
    chk("R2 mode kept after partial reset", int'(rd_data), fw ? dat(0) : 0);
    tick(0, 1, 0);
    chk("R3/R4 single word out", int'(rd_data), dat(0));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #100000;
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    @(posedge clk);
    #1;
    run_mode(1'b0);
    run_mode(1'b1);
    run_mode(1'b0);
    finish_run();
  end
endmodule